// File: doc/BRIEF.md
# Interrupt Vectoring and Wake-up Controller

This block gathers a group of maskable interrupt request lines and one separate high-priority request (the X-class request). It chooses the winning request and presents it to a CPU core as a pending flag and a 16-bit vector address. Two mask inputs come from the core's condition register. The I mask gates the maskable lines. The X mask gates the X-class request. The core nests interrupts only by clearing its I bit, so pre-emption among maskable requests is expressed entirely through the I input.

The vector address takes its upper byte from a base register that software can write. The lower byte is derived from the index of the winner. Requests are passed through a two-flop synchronizer before arbitration. The vector and the pending flag are registered.

A separate wake-up output leaves wait or stop mode. It is built without any clock, straight from the raw request pins. In stop mode only the lines marked as asynchronous sources count. The X-class request wakes the part whatever the state of its own mask.

Top module: `irq_vector_wake`

## Requirements
- R1: After reset the base register reads 0xFF, `int_pending` is 0 and `int_vector` is 0xFF80.
- R2: A cycle with `cfg_we` high loads `cfg_wdata` into the base. `cfg_base` shows it after that edge, and vectors issued afterwards carry it as their upper byte.
- R3: The vector is {base, 0x80 + 2*idx}. The X-class request has idx 0, so its vector is 0xFF80 by default. Maskable line k has idx k+1, so its vector is 0xFF82 + 2k by default.
- R4: Among pending maskable lines, the lowest-numbered line wins.
- R5: When `mask_x` is 0, a pending X-class request wins over any maskable line.
- R6: While `mask_i` is 1, no maskable line raises `int_pending`.
- R7: While `mask_x` is 1, the X-class request does not raise `int_pending`.
- R8: A request that rises before a clock edge, with its mask already clear, reaches `int_pending` on the third edge. It is not visible after the second edge.
- R9: In run mode (`pmode` = 0), `wake` is 0.
- R10: In wait mode (`pmode` = 1), `wake` is 1 exactly when the X-class request is high, or when `mask_i` is 0 and any maskable line is high.
- R11: In stop mode (`pmode` = 2 or 3), a maskable line contributes to `wake` only if its bit in `ASYNC_SRC` is set. The default is lines 0 to 3. `mask_i` = 1 still blocks all maskable lines.
- R12: In wait and stop mode, the X-class request drives `wake` to 1 even while `mask_x` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N_IRQ | Maskable request lines, line 0 highest priority |
| xirq_req | input | 1 | X-class high-priority request |
| mask_i | input | 1 | I mask from the core, 1 blocks maskable lines |
| mask_x | input | 1 | X mask from the core, 1 blocks X-class vectoring |
| pmode | input | 2 | Power mode: 0 run, 1 wait, 2 or 3 stop |
| cfg_we | input | 1 | Base register write enable |
| cfg_wdata | input | 8 | Base register write data |
| cfg_base | output | 8 | Current base register value |
| int_pending | output | 1 | A qualified request is pending |
| int_vector | output | 16 | Vector address of the winning request |
| wake | output | 1 | Combinational wake-up request |

## Verification
The wake-up properties are sampled on the clock even though `wake` has no clock. They therefore rely on request and mode inputs that change only between edges. The bench drives everything at the falling edge. The mask property assumes both masks have been held for a full cycle before `int_pending` is judged. The bench keeps the masks unchanged while any request is being judged, and waits three edges after every change so that the synchronizer and the output register have settled.

// File: rtl/irq_vector_wake_pkg.sv
package irq_vector_wake_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_STOP = 2'd2,
        PM_DEEP = 2'd3
    } pmode_e;

    typedef struct packed {
        logic       hit;
        logic [7:0] ofs;
    } pick_t;

    localparam logic [7:0] RESET_BASE = 8'hFF;
    localparam logic [7:0] OFS_FIRST  = 8'h80;

    function automatic logic [7:0] slot_ofs(input int unsigned idx);
        return OFS_FIRST + 8'(idx * 2);
    endfunction

endpackage

// File: rtl/iv_sync.sv
module iv_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[b];
                s2 <= s1;
            end
        end
        assign q[b] = s2;
    end
endmodule

// File: rtl/iv_arbiter.sv
module iv_arbiter
    import irq_vector_wake_pkg::*;
#(
    parameter int N_IRQ = 8
) (
    input  logic [N_IRQ-1:0] req,
    input  logic             xreq,
    input  logic             mask_i,
    input  logic             mask_x,
    output pick_t            pick
);
    always_comb begin
        pick.hit = 1'b0;
        pick.ofs = slot_ofs(0);
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (req[i] && !mask_i) begin
                pick.hit = 1'b1;
                pick.ofs = slot_ofs(i + 1);
            end
        end
        if (xreq && !mask_x) begin
            pick.hit = 1'b1;
            pick.ofs = slot_ofs(0);
        end
    end
endmodule

// File: rtl/iv_wake.sv
module iv_wake
    import irq_vector_wake_pkg::*;
#(
    parameter int               N_IRQ     = 8,
    parameter logic [N_IRQ-1:0] ASYNC_SRC = '1
) (
    input  logic [N_IRQ-1:0] req,
    input  logic             xreq,
    input  logic             mask_i,
    input  pmode_e           mode,
    output logic             wake
);
    logic any_all, any_async;

    assign any_all   = |req;
    assign any_async = |(req & ASYNC_SRC);

    always_comb begin
        unique case (mode)
            PM_RUN:  wake = 1'b0;
            PM_WAIT: wake = xreq | (!mask_i & any_all);
            default: wake = xreq | (!mask_i & any_async);
        endcase
    end
endmodule

// File: rtl/irq_vector_wake.sv
module irq_vector_wake
    import irq_vector_wake_pkg::*;
#(
    parameter int               N_IRQ     = 8,
    parameter logic [N_IRQ-1:0] ASYNC_SRC = N_IRQ'(8'h0F)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             xirq_req,
    input  logic             mask_i,
    input  logic             mask_x,
    input  logic [1:0]       pmode,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_base,
    output logic             int_pending,
    output logic [15:0]      int_vector,
    output logic             wake
);
    localparam int SYNC_W = N_IRQ + 1;

    logic [SYNC_W-1:0] req_sync;
    pick_t             pick;
    logic [7:0]        base_q;
    logic              pend_q;
    logic [15:0]       vec_q;

    iv_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({xirq_req, irq_req}),
        .q   (req_sync)
    );

    iv_arbiter #(.N_IRQ(N_IRQ)) u_arb (
        .req    (req_sync[N_IRQ-1:0]),
        .xreq   (req_sync[N_IRQ]),
        .mask_i (mask_i),
        .mask_x (mask_x),
        .pick   (pick)
    );

    iv_wake #(.N_IRQ(N_IRQ), .ASYNC_SRC(ASYNC_SRC)) u_wake (
        .req    (irq_req),
        .xreq   (xirq_req),
        .mask_i (mask_i),
        .mode   (pmode_e'(pmode)),
        .wake   (wake)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= RESET_BASE;
        end else if (cfg_we) begin
            base_q <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            vec_q  <= {RESET_BASE, slot_ofs(0)};
        end else begin
            pend_q <= pick.hit;
            vec_q  <= {base_q, pick.ofs};
        end
    end

    assign cfg_base    = base_q;
    assign int_pending = pend_q;
    assign int_vector  = vec_q;
endmodule

// File: rtl/irq_vector_wake_chk.sv
module irq_vector_wake_chk #(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [N_IRQ-1:0] irq_req,
    input logic             xirq_req,
    input logic             mask_i,
    input logic             mask_x,
    input logic [1:0]       pmode,
    input logic [7:0]       cfg_base,
    input logic             int_pending,
    input logic [15:0]      int_vector,
    input logic             wake
);
    // R1
    base_after_reset_chk: assert property (@(posedge clk)
        $fell(rst) |-> cfg_base == 8'hFF);

    // R3
    vec_even_chk: assert property (@(posedge clk) disable iff (rst)
        int_pending |-> (int_vector[0] == 1'b0 && int_vector[7] == 1'b1));

    // R6
    both_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_i && mask_x && $past(mask_i) && $past(mask_x) && !$past(rst))
            |=> !int_pending);

    // R9
    wake_run_chk: assert property (@(posedge clk) disable iff (rst)
        (pmode == 2'd0) |-> !wake);

    // R12
    wake_x_chk: assert property (@(posedge clk) disable iff (rst)
        (pmode != 2'd0 && xirq_req) |-> wake);

    // R10
    wake_imask_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_i && !xirq_req) |-> !wake);
endmodule

bind irq_vector_wake irq_vector_wake_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_req     (irq_req),
    .xirq_req    (xirq_req),
    .mask_i      (mask_i),
    .mask_x      (mask_x),
    .pmode       (pmode),
    .cfg_base    (cfg_base),
    .int_pending (int_pending),
    .int_vector  (int_vector),
    .wake        (wake)
);

// File: tb/test_irq_vector_wake.sv
`timescale 1ns/1ps
module test_irq_vector_wake;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_req = '0;
    logic          xirq_req = 1'b0;
    logic          mask_i = 1'b1;
    logic          mask_x = 1'b1;
    logic [1:0]    pmode = 2'd0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_wdata = 8'h00;
    logic [7:0]    cfg_base;
    logic          int_pending;
    logic [15:0]   int_vector;
    logic          wake;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] base_m = 8'hFF;

    always #2.5 clk = ~clk;

    irq_vector_wake i_irq_vector_wake (
        .clk(clk), .rst(rst), .irq_req(irq_req), .xirq_req(xirq_req),
        .mask_i(mask_i), .mask_x(mask_x), .pmode(pmode),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_base(cfg_base),
        .int_pending(int_pending), .int_vector(int_vector), .wake(wake)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [15:0] vec_of(input int idx);
        return {base_m, 8'h80 + 8'(idx * 2)};
    endfunction

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_all();
        irq_req = '0; xirq_req = 1'b0; mask_i = 1'b1; mask_x = 1'b1; pmode = 2'd0;
        settle();
    endtask

    task automatic t_reset();
        chk("R1 base", 32'(cfg_base), 32'hFF);
        chk("R1 pending", 32'(int_pending), 0);
        chk("R1 vector", 32'(int_vector), 32'hFF80);
    endtask

    task automatic t_single();
        mask_i = 1'b0;
        for (int k = 0; k < N; k++) begin
            irq_req = '0; irq_req[k] = 1'b1;
            settle();
            chk("R3 pending", 32'(int_pending), 1);
            chk("R3 vector", 32'(int_vector), 32'(vec_of(k + 1)));
        end
        clear_all();
    endtask

    task automatic t_priority();
        mask_i = 1'b0;
        irq_req = 8'b1010_1000;
        settle();
        chk("R4 low wins", 32'(int_vector), 32'(vec_of(4)));
        irq_req = 8'b1000_0000;
        settle();
        chk("R4 only top", 32'(int_vector), 32'(vec_of(8)));
        clear_all();
    endtask

    task automatic t_xprio();
        mask_i = 1'b0; mask_x = 1'b0;
        irq_req = 8'h01; xirq_req = 1'b1;
        settle();
        chk("R5 x wins", 32'(int_vector), 32'(vec_of(0)));
        mask_x = 1'b1;
        settle();
        chk("R7 x masked falls to line0", 32'(int_vector), 32'(vec_of(1)));
        irq_req = '0;
        settle();
        chk("R7 x masked not pending", 32'(int_pending), 0);
        clear_all();
    endtask

    task automatic t_imask();
        mask_i = 1'b1; mask_x = 1'b0;
        irq_req = 8'hFF;
        settle();
        chk("R6 i masked", 32'(int_pending), 0);
        mask_i = 1'b0;
        settle();
        chk("R6 i cleared nests", 32'(int_pending), 1);
        clear_all();
    endtask

    task automatic t_latency();
        mask_i = 1'b0;
        settle();
        irq_req = 8'h04;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R8 not after two edges", 32'(int_pending), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 after third edge", 32'(int_pending), 1);
        clear_all();
    endtask

    task automatic t_base();
        cfg_we = 1'b1; cfg_wdata = 8'h3C;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0; base_m = 8'h3C;
        chk("R2 readback", 32'(cfg_base), 32'h3C);
        mask_i = 1'b0; irq_req = 8'h02;
        settle();
        chk("R2 vector base", 32'(int_vector), 32'(vec_of(2)));
        clear_all();
    endtask

    task automatic t_wake_run();
        pmode = 2'd0; mask_i = 1'b0; irq_req = 8'hFF; xirq_req = 1'b1;
        #1;
        chk("R9 run no wake", 32'(wake), 0);
        clear_all();
    endtask

    task automatic t_wake_wait();
        pmode = 2'd1; mask_i = 1'b0; irq_req = 8'h80;
        #1;
        chk("R10 wait sync line wakes", 32'(wake), 1);
        mask_i = 1'b1;
        #1;
        chk("R10 wait i masked", 32'(wake), 0);
        irq_req = '0; mask_i = 1'b0;
        #1;
        chk("R10 wait idle", 32'(wake), 0);
        clear_all();
    endtask

    task automatic t_wake_stop();
        pmode = 2'd2; mask_i = 1'b0; irq_req = 8'h10;
        #1;
        chk("R11 stop sync line ignored", 32'(wake), 0);
        irq_req = 8'h08;
        #1;
        chk("R11 stop async line wakes", 32'(wake), 1);
        mask_i = 1'b1;
        #1;
        chk("R11 stop i masked", 32'(wake), 0);
        clear_all();
    endtask

    task automatic t_wake_x();
        mask_x = 1'b1; mask_i = 1'b1; xirq_req = 1'b1;
        pmode = 2'd1;
        #1;
        chk("R12 x wakes wait", 32'(wake), 1);
        pmode = 2'd2;
        #1;
        chk("R12 x wakes stop", 32'(wake), 1);
        clear_all();
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single();
        t_priority();
        t_xprio();
        t_imask();
        t_latency();
        t_wake_run();
        t_wake_wait();
        t_wake_stop();
        t_wake_x();
        t_base();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule